// File: doc/BRIEF.md
# Dual-Modulus Alternating Clock Divider

This block derives a slow clock, on the order of 32.768 kHz, from a fast reference clock. It does this by switching between two integer divide ratios. The divider holds the first ratio for a programmed number of output periods. It then holds the second ratio for its own programmed number of periods, and the pattern repeats. The average output frequency therefore falls between the two plain integer divisions. A single-ratio mode and a bypass path are also available.

Configuration is held in two 32-bit control words, written through a one-cycle write strobe with a word select. Two gate enables control the clock path. The input gate starts the divider. The output gate is raised only once the divider has settled. The output gate is sampled only while the divided output is low, so turning it on or off never produces a shortened pulse. All logic runs in the reference clock domain. The divided output is a level with a near-50% duty cycle, and a companion one-cycle tick marks the start of each output period.

Top module: `dmcd_clkdiv`

## Requirements
- R1: A write with `wr_sel`=0 loads control word A. In word A, the first ratio field sits in bits 11:0, the second ratio field in bits 23:12, dual mode in bit 28, the output gate in bit 30 and the input gate in bit 31. A write with `wr_sel`=1 loads control word B. In word B, the first count field sits in bits 11:0, the second count field in bits 23:12, and bypass in bit 24.
- R2: A ratio field value k gives an output period of exactly k+1 reference cycles. `period_tick` is high only in the first cycle of each period.
- R3: `clk_out` is high for the first floor((k+1)/2) cycles of each period and low for the rest of it.
- R4: With dual mode clear, every period uses the first ratio, whatever the second ratio and the count fields hold.
- R5: With dual mode set, the divider runs (first count + 1) periods at the first ratio, then (second count + 1) periods at the second ratio, and then repeats. Each run starts with the first ratio.
- R6: A change to a ratio field written in the middle of a period leaves that period's length unchanged and applies from the next period.
- R7: While the input gate is low, `clk_out` and `period_tick` stay low. When the gate is raised, the sequence restarts with a full period at the first ratio.
- R8: With bypass set and both gates enabled, `clk_out` follows the reference clock and `period_tick` is high on every cycle. With the input gate low, both outputs stay low.
- R9: While the effective output gate is off, `clk_out` and `period_tick` stay low. The output gate setting is only taken while the divided level is low, so a high phase that has already started always runs to its full length.
- R10: An active-low synchronous reset clears the counters, all control fields and both gates, so both outputs stay low after reset.
- R11: With a 24 MHz reference and ratio fields 732/731 with count fields 7/10, one full cycle is 8 periods of 733 cycles plus 11 periods of 732 cycles (13916 cycles). This averages about 32768 Hz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_sel | input | 1 | Control word select (0 = word A, 1 = word B) |
| wr_data | input | DATA_W | Control word write data |
| clk_out | output | 1 | Divided (or bypassed) clock output |
| period_tick | output | 1 | One-cycle marker at the start of each output period |

## Verification
The bench builds the block with its default parameters. With small ratio and count field values, every combination of ratios 1 to 5 and counts 1 to 3 in dual mode can be swept period by period. The sweep includes the ratio-1 case, which has no high phase. The full 12-bit fields are then exercised with the 24 MHz setting over one complete 13916-cycle run. Directed cases cover mid-period ratio writes, gate changes during a high phase, input-gate restart from the second-ratio phase, and bypass.

// File: rtl/dmcd_pkg.sv
package dmcd_pkg;

   // control word A layout
   localparam int unsigned A_RAT1_LSB  = 0;
   localparam int unsigned A_RAT2_LSB  = 12;
   localparam int unsigned A_DUAL_BIT  = 28;
   localparam int unsigned A_OGATE_BIT = 30;
   localparam int unsigned A_IGATE_BIT = 31;

   // control word B layout
   localparam int unsigned B_CNT1_LSB  = 0;
   localparam int unsigned B_CNT2_LSB  = 12;
   localparam int unsigned B_BYP_BIT   = 24;

   localparam int unsigned SLOT_W      = 12;
   localparam int unsigned NUM_WORDS   = 2;

   typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;

endpackage

// File: rtl/dmcd_cfg_regs.sv
module dmcd_cfg_regs
   import dmcd_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FIELD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [FIELD_W-1:0] rat1,
   output logic [FIELD_W-1:0] rat2,
   output logic [FIELD_W-1:0] cnt1,
   output logic [FIELD_W-1:0] cnt2,
   output logic               dual,
   output logic               byp,
   output logic               in_gate,
   output logic               out_gate
);

   generate
      if (DATA_W < 32) begin : g_bad_data
         $error("dmcd_cfg_regs: DATA_W must be at least 32");
      end
      if (FIELD_W < 1 || FIELD_W > SLOT_W) begin : g_bad_field
         $error("dmcd_cfg_regs: FIELD_W must lie in 1..12");
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   // one storage process per control word
   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         if (w == 0) begin : g_a
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  rat1     <= '0;
                  rat2     <= '0;
                  dual     <= 1'b0;
                  out_gate <= 1'b0;
                  in_gate  <= 1'b0;
               end else if (wr_en && (wr_sel == 1'(w))) begin
                  rat1     <= wr_data[A_RAT1_LSB +: FIELD_W];
                  rat2     <= wr_data[A_RAT2_LSB +: FIELD_W];
                  dual     <= wr_data[A_DUAL_BIT];
                  out_gate <= wr_data[A_OGATE_BIT];
                  in_gate  <= wr_data[A_IGATE_BIT];
               end
            end
         end else begin : g_b
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  cnt1 <= '0;
                  cnt2 <= '0;
                  byp  <= 1'b0;
               end else if (wr_en && (wr_sel == 1'(w))) begin
                  cnt1 <= wr_data[B_CNT1_LSB +: FIELD_W];
                  cnt2 <= wr_data[B_CNT2_LSB +: FIELD_W];
                  byp  <= wr_data[B_BYP_BIT];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dmcd_core.sv
module dmcd_core
   import dmcd_pkg::*;
#(
   parameter int unsigned FIELD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               dual,
   input  logic [FIELD_W-1:0] rat1,
   input  logic [FIELD_W-1:0] rat2,
   input  logic [FIELD_W-1:0] cnt1,
   input  logic [FIELD_W-1:0] cnt2,
   output logic               lvl,
   output logic               tick
);

   generate
      if (FIELD_W < 1) begin : g_bad_field
         $error("dmcd_core: FIELD_W must be positive");
      end
   endgenerate

   localparam int unsigned HALF_W = FIELD_W + 1;

   logic [FIELD_W-1:0] cyc_q, lim_q, rep_q;
   phase_e             ph_q;

   logic               at_end, rep_done;
   logic [FIELD_W-1:0] rep_lim, rep_nx, lim_nx;
   phase_e             ph_nx;
   logic [HALF_W-1:0]  high_len;

   always_comb begin
      at_end   = (cyc_q == lim_q);
      rep_lim  = (ph_q == PH_FIRST) ? cnt1 : cnt2;
      rep_done = (rep_q == rep_lim);
      if (!dual)
         ph_nx = PH_FIRST;
      else if (rep_done)
         ph_nx = (ph_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
      else
         ph_nx = ph_q;
      rep_nx   = (!dual || rep_done) ? '0 : rep_q + 1'b1;
      lim_nx   = (ph_nx == PH_SECOND) ? rat2 : rat1;
      high_len = ({1'b0, lim_q} + 1'b1) >> 1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q <= '0;
         lim_q <= '0;
         rep_q <= '0;
         ph_q  <= PH_FIRST;
      end else if (!run) begin
         cyc_q <= '0;
         rep_q <= '0;
         ph_q  <= PH_FIRST;
         lim_q <= rat1;
      end else if (at_end) begin
         cyc_q <= '0;
         rep_q <= rep_nx;
         ph_q  <= ph_nx;
         lim_q <= lim_nx;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   assign lvl  = run && ({1'b0, cyc_q} < high_len);
   assign tick = run && (cyc_q == '0);

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cyc_q <= lim_q))
      else $error("cycle counter beyond period limit");

   assert_lim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_end) |=> (!run || $stable(lim_q)))
      else $error("period limit changed mid-period");

   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cyc_q == '0 && rep_q == '0 && ph_q == PH_FIRST))
      else $error("idle divider not parked at first phase");

   assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !dual && at_end) |=> (ph_q == PH_FIRST))
      else $error("single mode left first ratio");

endmodule

// File: rtl/dmcd_outgate.sv
module dmcd_outgate (
   input  logic clk,
   input  logic rst_n,
   input  logic out_gate,
   input  logic lvl,
   output logic gate_on
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         gate_on <= 1'b0;
      else if (!lvl)
         gate_on <= out_gate;
   end

   assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lvl |=> $stable(gate_on))
      else $error("output gate moved during high phase");

endmodule

// File: rtl/dmcd_clkdiv.sv
module dmcd_clkdiv #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FIELD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              clk_out,
   output logic              period_tick
);

   logic [FIELD_W-1:0] rat1, rat2, cnt1, cnt2;
   logic               dual, byp, in_gate, out_gate;
   logic               run, lvl, div_tick, gate_on;

   dmcd_cfg_regs #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rat1     (rat1),
      .rat2     (rat2),
      .cnt1     (cnt1),
      .cnt2     (cnt2),
      .dual     (dual),
      .byp      (byp),
      .in_gate  (in_gate),
      .out_gate (out_gate)
   );

   assign run = in_gate && !byp;

   dmcd_core #(.FIELD_W(FIELD_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .dual  (dual),
      .rat1  (rat1),
      .rat2  (rat2),
      .cnt1  (cnt1),
      .cnt2  (cnt2),
      .lvl   (lvl),
      .tick  (div_tick)
   );

   dmcd_outgate u_ogate (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_gate (out_gate),
      .lvl      (lvl),
      .gate_on  (gate_on)
   );

   assign clk_out     = byp ? (clk & in_gate & gate_on) : (lvl & gate_on);
   assign period_tick = gate_on & (byp ? in_gate : div_tick);

   assert_tick_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |-> !period_tick)
      else $error("tick while output gate off");

   assert_in_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_gate |-> (!period_tick && !clk_out))
      else $error("output active with input gate off");

   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (!gate_on && !in_gate))
      else $error("gates not cleared by reset");

endmodule

// File: tb/dmcd_clkdiv_tb.sv
`timescale 1ns/1ps
module dmcd_clkdiv_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        clk_out, period_tick;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dmcd_clkdiv u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .clk_out     (clk_out),
      .period_tick (period_tick)
   );

   function automatic logic [31:0] word_a(int r1, int r2, bit dm, bit og, bit ig);
      return (32'(ig) << 31) | (32'(og) << 30) | (32'(dm) << 28) |
             (32'(r2) << 12) | 32'(r1);
   endfunction

   function automatic logic [31:0] word_b(int c1, int c2, bit bp);
      return (32'(bp) << 24) | (32'(c2) << 12) | 32'(c1);
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the following negedge
   task automatic wr(bit sel, logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // called at the negedge of a period's first cycle
   task automatic run_period(int len, string req);
      int hi = 0;
      int bad = 0;
      for (int i = 0; i < len; i++) begin
         if (clk_out) hi++;
         if (period_tick != (i == 0)) bad++;
         @(negedge clk);
      end
      chk(bad == 0, {req, " tick placement"}, bad, 0);
      chk(hi == len / 2, {req, " high length"}, hi, len / 2);
   endtask

   task automatic quiet(int len, string req);
      int act = 0;
      for (int i = 0; i < len; i++) begin
         if (clk_out || period_tick) act++;
         @(negedge clk);
      end
      chk(act == 0, req, act, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int c;
      int total;
      longint freq;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      quiet(5, "R10 outputs after reset");

      // R5 dual-mode sweep with small fields (R1 field placement, R2, R3, R7 restart)
      for (int r1 = 0; r1 < 5; r1++)
         for (int r2 = 0; r2 < 5; r2++)
            for (int c1 = 0; c1 < 3; c1++)
               for (int c2 = 0; c2 < 3; c2++) begin
                  wr(0, word_a(r1, r2, 1, 1, 0));
                  wr(1, word_b(c1, c2, 0));
                  wr(0, word_a(r1, r2, 1, 1, 1));
                  for (int rep = 0; rep < 2; rep++) begin
                     for (int a = 0; a <= c1; a++) run_period(r1 + 1, "R5 first-ratio run (R1 R2 R3)");
                     for (int b = 0; b <= c2; b++) run_period(r2 + 1, "R5 second-ratio run (R1 R2 R3)");
                  end
               end

      // R4 single mode ignores second ratio and counts
      for (int r1 = 0; r1 < 8; r1++) begin
         wr(0, word_a(r1, 5, 0, 1, 0));
         wr(1, word_b(1, 1, 0));
         wr(0, word_a(r1, 5, 0, 1, 1));
         for (int p = 0; p < 6; p++) run_period(r1 + 1, "R4 single mode");
      end

      // R7 input gate drop during second-ratio phase, restart at first ratio
      wr(0, word_a(1, 3, 1, 1, 0));
      wr(1, word_b(0, 1, 0));
      wr(0, word_a(1, 3, 1, 1, 1));
      run_period(2, "R7 pre first");
      run_period(4, "R7 pre second");
      wr(0, word_a(1, 3, 1, 1, 0));
      quiet(8, "R7 outputs low with input gate off");
      wr(0, word_a(1, 3, 1, 1, 1));
      run_period(2, "R7 restart first ratio");
      run_period(4, "R7 restart second ratio a");
      run_period(4, "R7 restart second ratio b");
      run_period(2, "R7 back to first ratio");

      // R6 ratio written mid-period applies at boundary
      wr(0, word_a(9, 0, 0, 1, 0));
      wr(0, word_a(9, 0, 0, 1, 1));
      wr(0, word_a(3, 0, 0, 1, 1));
      c = 1;
      while (!period_tick && c < 50) begin @(negedge clk); c++; end
      chk(c == 10, "R6 current period keeps old ratio", c, 10);
      run_period(4, "R6 new ratio next period a");
      run_period(4, "R6 new ratio next period b");

      // R9 output gate cleared during high phase
      wr(0, word_a(9, 0, 0, 1, 0));
      wr(0, word_a(9, 0, 0, 1, 1));
      wr(0, word_a(9, 0, 0, 0, 1));
      c = 0;
      for (int i = 1; i < 10; i++) begin
         if (clk_out) c++;
         @(negedge clk);
      end
      chk(c == 4, "R9 high phase not shortened", c, 4);
      quiet(20, "R9 outputs low with output gate off");
      wr(0, word_a(9, 0, 0, 1, 1));
      c = 0;
      while (!period_tick && c < 30) begin @(negedge clk); c++; end
      chk(period_tick == 1'b1, "R9 output resumes", period_tick, 1);
      run_period(10, "R9 first period after gate on");

      // R8 bypass
      wr(1, word_b(0, 0, 1));
      wr(0, word_a(9, 0, 0, 1, 1));
      chk(clk_out == 1'b0, "R8 bypass low phase", clk_out, 0);
      chk(period_tick == 1'b1, "R8 bypass tick every cycle", period_tick, 1);
      @(posedge clk); #1;
      chk(clk_out == 1'b1, "R8 bypass high phase", clk_out, 1);
      @(negedge clk);
      wr(0, word_a(9, 0, 0, 1, 0));
      @(posedge clk); #1;
      chk(clk_out == 1'b0, "R8 bypass with input gate off", clk_out, 0);
      chk(period_tick == 1'b0, "R8 bypass tick with input gate off", period_tick, 0);
      @(negedge clk);
      wr(1, word_b(0, 0, 0));

      // R11 24 MHz setting
      wr(0, word_a(732, 731, 1, 1, 0));
      wr(1, word_b(7, 10, 0));
      wr(0, word_a(732, 731, 1, 1, 1));
      for (int a = 0; a < 8; a++) run_period(733, "R11 first ratio 733");
      for (int b = 0; b < 11; b++) run_period(732, "R11 second ratio 732");
      chk(period_tick == 1'b1, "R11 sequence wraps", period_tick, 1);
      total = 8 * 733 + 11 * 732;
      chk(total == 13916, "R11 cycles per sequence", total, 13916);
      freq = (64'd24000000 * 19 + total / 2) / total;
      chk(freq == 32768, "R11 average frequency", freq, 32768);
      run_period(733, "R11 first ratio after wrap");

      // R10 reset mid-run clears gates
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      quiet(20, "R10 outputs after mid-run reset");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule